// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character at a time into a serial frame on a single transmit line. The shape of each frame is chosen at run time. A character can carry five to nine data bits. A parity bit can be added, even or odd, or left out. The frame ends with one or two stop bits. Characters arrive over a valid/ready stream interface and wait in a single holding register. A new character can be taken while the previous frame is still on the line, so frames can follow each other without any gap.

There are two timing modes. In asynchronous mode, each bit lasts one period of an external one-cycle baud tick. In synchronous master mode, the block also drives a serial clock. Each baud tick is one half of that clock, and a polarity input picks the edge on which the data changes. The receiver samples on the other edge.

Back-pressure rule: `in_ready` is high exactly when the holding register is empty. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold its character, and nothing on `in_data` is taken. Once accepted, the character moves into the shifter at the next frame start, and this frees the holding register.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and whenever nothing is in flight, `tx` is 1, `busy` is 0 and `in_ready` is 1. Outside a frame, `sclk` rests at the level of `cfg_pol`.
- R2: A frame begins at the first baud-tick cycle after a character sits in the holding register. Its first bit is a single start bit at 0.
- R3: The data bits follow the start bit, least significant bit first. `cfg_len` codes 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 bits. Codes 5 to 7 also select 9 bits. Higher `in_data` bits beyond the count are not sent.
- R4: `cfg_parity` 2'b10 adds an even-parity bit and 2'b11 adds an odd-parity bit. Codes 2'b00 and 2'b01 add none. The parity bit goes right after the last data bit. It is computed only over the sent data bits, so that the ones in data plus parity number even (or odd).
- R5: `cfg_two_stop` = 0 ends the frame with one stop bit at 1. A value of 1 ends it with two.
- R6: If a character is waiting when the last stop bit ends, its start bit follows at once. Otherwise the line returns to idle high.
- R7: `in_ready` equals "holding register empty". While it is low, `in_valid` and `in_data` have no effect on what is transmitted.
- R8: `busy` is 1 from the edge that accepts a character until the end of the last stop bit of the last frame.
- R9: The format inputs (`cfg_len`, `cfg_parity`, `cfg_two_stop`, `cfg_sync`, `cfg_pol`) are sampled at the start of a frame. Changing them mid-frame does not alter that frame.
- R10: In asynchronous mode (`cfg_sync` = 0), each bit lasts exactly one baud-tick period, and `tx` changes only in the cycle after a tick.
- R11: In synchronous mode (`cfg_sync` = 1), each bit lasts two ticks and `sclk` toggles on every tick during a frame. With `cfg_pol` = 0, `tx` changes together with a rising `sclk`. With `cfg_pol` = 1, it changes with a falling `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle bit (async) or half-bit (sync) enable |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding register empty, character can be taken |
| in_data | input | DATA_W (9) | Character, LSB sent first |
| cfg_len | input | LEN_W (3) | Data-bit count code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_sync | input | 1 | 1 selects synchronous master mode |
| cfg_pol | input | 1 | Serial clock polarity / data-change edge |
| tx | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock, synchronous mode |
| busy | output | 1 | Character pending or frame on the line |

## Verification
A wrong bit counter or a wrong frame image shows on `tx` within one bit period. Such a fault appears as a misplaced parity or stop value, or as a frame that ends a bit early or late. A misplaced end also shows up at once as a wrong `busy` edge or a missing back-to-back start bit. A wrong half-bit phase in synchronous mode appears within one tick, as data moving on the sampling edge of `sclk`. A holding register that loses its full flag shows up in the next frame as a replaced or dropped character.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;
  // parity code: bit1 enables, bit0 selects odd
  localparam logic [1:0] PAR_EVEN = 2'b10;
  localparam logic [1:0] PAR_ODD  = 2'b11;

  // number of data bits for a length code, clamped at the data width
  function automatic int data_count(input int code, input int max_bits);
    if (code > max_bits - 5) return max_bits;
    return code + 5;
  endfunction
endpackage

// File: rtl/sft_hold.sv
`timescale 1ns/1ps
module sft_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q
);
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full) begin
      full   <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // a waiting character is neither lost nor overwritten
  assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data_q)));
endmodule

// File: rtl/sft_build.sv
`timescale 1ns/1ps
module sft_build #(
  parameter int DATA_W  = 9,
  parameter int LEN_W   = 3,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [LEN_W-1:0]   len_code,
  input  logic [1:0]         parity,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  import sft_pkg::*;

  always_comb begin
    int   n;
    int   pos;
    logic acc;
    n     = data_count(int'(len_code), DATA_W);
    frame = '1;
    frame[0] = 1'b0;
    acc   = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        frame[i+1] = data[i];
        acc        = acc ^ data[i];
      end
    end
    pos = n + 1;
    for (int k = 1; k < FRAME_W; k++) begin
      if (parity[1] && k == pos) frame[k] = acc ^ parity[0];
    end
    nbits = CNT_W'(1 + n + (parity[1] ? 1 : 0) + (two_stop ? 2 : 1));
  end
endmodule

// File: rtl/sft_engine.sv
`timescale 1ns/1ps
module sft_engine #(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               pending,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  input  logic               cfg_sync,
  input  logic               cfg_pol,
  output logic               take,
  output logic               active,
  output logic               frm_sync,
  output logic               frm_pol,
  output logic               tx,
  output logic               sclk
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               half;
  logic               boundary;
  logic               last;

  assign boundary = baud_tick && !half;
  assign last     = active && (left == CNT_W'(1));
  assign take     = boundary && pending && (!active || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      half     <= 1'b0;
      shreg    <= '1;
      left     <= '0;
      frm_sync <= 1'b0;
      frm_pol  <= 1'b0;
    end else if (baud_tick) begin
      if (half) begin
        half <= 1'b0;
      end else if (take) begin
        shreg    <= frame;
        left     <= nbits;
        active   <= 1'b1;
        frm_sync <= cfg_sync;
        frm_pol  <= cfg_pol;
        half     <= cfg_sync;
      end else if (active) begin
        if (last) begin
          active <= 1'b0;
          left   <= '0;
        end else begin
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - CNT_W'(1);
          half  <= frm_sync;
        end
      end
    end
  end

  assign tx   = active ? shreg[0] : 1'b1;
  assign sclk = active ? (frm_pol ^ half) : cfg_pol;

  // every frame opens with a low start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (tx == 1'b0));
  // half-bit phase exists only in synchronous frames
  assert_half_sync_R11: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> (active && frm_sync));
endmodule

// File: rtl/serial_frame_tx.sv
`timescale 1ns/1ps
module serial_frame_tx #(
  parameter int DATA_W = 9,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic              cfg_sync,
  input  logic              cfg_pol,
  output logic              tx,
  output logic              sclk,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               full;
  logic               take;
  logic               active;
  logic               frm_sync;
  logic               frm_pol;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  sft_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .take(take), .full(full), .data_q(hold_data)
  );

  sft_build #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
    .data(hold_data), .len_code(cfg_len), .parity(cfg_parity),
    .two_stop(cfg_two_stop), .frame(frame), .nbits(nbits)
  );

  sft_engine #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .pending(full),
    .frame(frame), .nbits(nbits), .cfg_sync(cfg_sync), .cfg_pol(cfg_pol),
    .take(take), .active(active), .frm_sync(frm_sync), .frm_pol(frm_pol),
    .tx(tx), .sclk(sclk)
  );

  assign busy = full || active;

  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx && in_ready));
  assert_tick_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx));
  assert_change_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frm_sync && !$stable(tx)) |-> (sclk != frm_pol));
  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(baud_tick) && tx));
endmodule

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic [2:0] cfg_len = 3'd3;
  logic [1:0] cfg_parity = 2'b00;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_sync = 1'b0;
  logic       cfg_pol = 1'b0;
  logic       tx, sclk, busy;
  int total = 0;
  int bad = 0;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop), .cfg_sync(cfg_sync),
    .cfg_pol(cfg_pol), .tx(tx), .sclk(sclk), .busy(busy)
  );

  always #10 clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % 8;
      baud_tick = (tc == 0);
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic boundary();
    do @(posedge clk); while (baud_tick !== 1'b1);
    #2;
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_frame(input logic [8:0] d, input int code, input logic [1:0] par,
                              input bit two, input bit sync, input bit pol, input string req);
    logic exp [16];
    int   cnt;
    int   n;
    logic p;
    n = (code > 4) ? 9 : code + 5;
    exp[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp[i+1] = d[i];
      p = p ^ d[i];
    end
    cnt = n + 1;
    if (par[1]) begin
      exp[cnt] = par[0] ? ~p : p;
      cnt++;
    end
    exp[cnt] = 1'b1; cnt++;
    if (two) begin exp[cnt] = 1'b1; cnt++; end
    for (int b = 0; b < cnt; b++) begin
      boundary();
      check($sformatf("%s bit%0d", req, b), {15'd0, tx}, {15'd0, exp[b]});
      check("R8 busy in frame", {15'd0, busy}, 16'd1);
      if (sync) begin
        check("R11 change edge", {15'd0, sclk}, {15'd0, ~pol});
        boundary();
        check("R11 held over sample edge", {15'd0, tx}, {15'd0, exp[b]});
        check("R11 sample edge", {15'd0, sclk}, {15'd0, pol});
      end else begin
        repeat (4) @(negedge clk);
        check("R10 stable mid-bit", {15'd0, tx}, {15'd0, exp[b]});
      end
    end
  endtask

  task automatic expect_idle(input bit pol, input string req);
    boundary();
    check({req, " tx idle"}, {15'd0, tx}, 16'd1);
    check("R8 busy dropped", {15'd0, busy}, 16'd0);
    check("R1 ready idle", {15'd0, in_ready}, 16'd1);
    check("R1 sclk rest", {15'd0, sclk}, {15'd0, pol});
  endtask

  task automatic set_fmt(input logic [2:0] l, input logic [1:0] p, input bit two,
                         input bit sync, input bit pol);
    @(negedge clk);
    cfg_len = l; cfg_parity = p; cfg_two_stop = two; cfg_sync = sync; cfg_pol = pol;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tx", {15'd0, tx}, 16'd1);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 ready", {15'd0, in_ready}, 16'd1);
    check("R1 sclk", {15'd0, sclk}, 16'd0);
  endtask

  task automatic t_async_formats();
    set_fmt(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    send(9'h0A5);
    check("R8 busy after accept", {15'd0, busy}, 16'd1);
    expect_frame(9'h0A5, 3, 2'b00, 1'b0, 1'b0, 1'b0, "R3 8N1");
    expect_idle(1'b0, "R6");
    set_fmt(3'd4, 2'b10, 1'b1, 1'b0, 1'b0);
    send(9'h1B3);
    expect_frame(9'h1B3, 4, 2'b10, 1'b1, 1'b0, 1'b0, "R4 R5 9E2");
    expect_idle(1'b0, "R5");
    set_fmt(3'd0, 2'b11, 1'b0, 1'b0, 1'b0);
    send(9'h0F6);
    expect_frame(9'h0F6, 0, 2'b11, 1'b0, 1'b0, 1'b0, "R4 5O1");
    expect_idle(1'b0, "R4");
    set_fmt(3'd2, 2'b10, 1'b0, 1'b0, 1'b0);
    send(9'h1D5);
    expect_frame(9'h1D5, 2, 2'b10, 1'b0, 1'b0, 1'b0, "R4 7E1");
    expect_idle(1'b0, "R4");
    set_fmt(3'd6, 2'b01, 1'b1, 1'b0, 1'b0);
    send(9'h16C);
    expect_frame(9'h16C, 6, 2'b00, 1'b1, 1'b0, 1'b0, "R3 code6");
    expect_idle(1'b0, "R3");
  endtask

  task automatic t_back_to_back();
    set_fmt(3'd3, 2'b11, 1'b0, 1'b0, 1'b0);
    send(9'h03C);
    fork
      expect_frame(9'h03C, 3, 2'b11, 1'b0, 1'b0, 1'b0, "R6 first");
      begin
        send(9'h0C1);
        check("R7 ready low when full", {15'd0, in_ready}, 16'd0);
        in_valid = 1'b1;
        in_data  = 9'h055;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
      end
    join
    expect_frame(9'h0C1, 3, 2'b11, 1'b0, 1'b0, 1'b0, "R6 R7 second");
    expect_idle(1'b0, "R6");
  endtask

  task automatic t_cfg_hold();
    set_fmt(3'd3, 2'b00, 1'b0, 1'b0, 1'b0);
    send(9'h09E);
    fork
      expect_frame(9'h09E, 3, 2'b00, 1'b0, 1'b0, 1'b0, "R9 held format");
      begin
        repeat (20) @(negedge clk);
        cfg_len = 3'd0; cfg_parity = 2'b11; cfg_two_stop = 1'b1;
      end
    join
    expect_idle(1'b0, "R9");
  endtask

  task automatic t_sync();
    set_fmt(3'd1, 2'b10, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R1 sclk idle pol0", {15'd0, sclk}, 16'd0);
    send(9'h02D);
    expect_frame(9'h02D, 1, 2'b10, 1'b0, 1'b1, 1'b0, "R11 pol0");
    expect_idle(1'b0, "R11");
    set_fmt(3'd3, 2'b00, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R1 sclk idle pol1", {15'd0, sclk}, 16'd1);
    send(9'h0B7);
    expect_frame(9'h0B7, 3, 2'b00, 1'b1, 1'b1, 1'b1, "R11 pol1");
    expect_idle(1'b1, "R11");
  endtask

  initial begin
    t_reset();
    t_async_formats();
    t_back_to_back();
    t_cfg_hold();
    t_sync();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule